// File: doc/BRIEF.md
# Indexed Byte-Aligned Transfer Register Reader

This block holds a small bank of 32-bit transfer-in registers and lets any caller read four consecutive bytes from any byte position in the bank. The position comes from a runtime pointer rather than a fixed register number. Software loads the pointer with a single control write that carries an absolute byte address. That one write sets both the word index and the byte offset within the word. Each indexed read returns the four bytes starting at the pointer, packed big-endian into one word. The read can optionally advance the pointer by one word, so that back-to-back reads walk through a header that begins at an arbitrary byte.

The bank and the pointer are shared by all eight hardware contexts, with no per-context state. Any context can write a register, move the pointer or read through it. A pointer write lands after a fixed latency, and reads issued before that still see the old pointer. Both reads and pointer advances wrap modulo the window size.

Top module: `xir_index_reader`

## Requirements
- R1: While `rst` is high and on the cycle after it, `rd_valid` is 0 and `rd_data` is 0. After reset every bank byte is 0 and the pointer is byte 0.
- R2: When `wr_en` is high, `wr_data` is stored in register `wr_idx`. Register n holds window bytes 4n..4n+3, with byte 4n in bits 31:24 and byte 4n+3 in bits 7:0.
- R3: When `rd_en` is high at a clock edge, then after that edge `rd_valid` is 1 and `rd_data` holds window bytes p, p+1, p+2 and p+3, where p is the pointer. Byte p is in bits 31:24. After any edge without `rd_en`, `rd_valid` is 0.
- R4: A read whose bytes run past byte 0x1f continues from byte 0x00 (modulo 32).
- R5: `idx_wr_addr` is an absolute byte address. Only its bits 4:0 select the byte, and bits 7:5 are ignored.
- R6: A pointer write sampled at edge t is used by reads sampled at edge t+3 and later. Reads at edges t+1 and t+2 still use the previous pointer.
- R7: A read with `rd_inc` high returns data at the current pointer, and the pointer then becomes p+4 modulo 32 for the next read.
- R8: `rd_inc` without `rd_en` leaves the pointer unchanged.
- R9: If a pending pointer write lands at the same edge as a post-increment, the written address wins and the increment is dropped.
- R10: A read at the same edge as a write to the register it covers returns the register's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bank write strobe |
| wr_idx | input | 3 | Register number to write |
| wr_data | input | 32 | Register write data |
| idx_wr_en | input | 1 | Pointer write strobe |
| idx_wr_addr | input | 8 | Absolute byte address for the pointer |
| rd_en | input | 1 | Indexed read strobe |
| rd_inc | input | 1 | Advance the pointer by one word with this read |
| rd_data | output | 32 | Aligned read result |
| rd_valid | output | 1 | Read result valid |

## Verification
The bench builds the block with its default parameters: eight 32-bit registers and a three-cycle pointer latency. The 32-byte window is small enough to sweep every start offset with a post-incremented follow-up read, which exercises every read that crosses a register boundary and every wrap past byte 0x1f. Half of the sweep sets the ignored upper address bits. Directed sequences then place reads one, two and three cycles after a pointer write. They also collide a landing pointer write with an increment and overlap a read with a bank write.

// File: rtl/xir_pkg.sv
package xir_pkg;

    localparam int BYTE_W    = 8;
    localparam int DEF_WORDS = 8;
    localparam int DEF_WORD_W = 32;
    localparam int DEF_LAT   = 3;
    localparam int CTRL_W    = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // pending pointer load travelling through the latency pipe
    typedef struct packed {
        logic              vld;
        logic [CTRL_W-1:0] addr;
    } idx_load_t;

    // result register of the read port
    typedef struct packed {
        logic                  vld;
        logic [DEF_WORD_W-1:0] data;
    } rd_out_t;

    function automatic int lanes_of(input int word_w);
        return word_w / BYTE_W;
    endfunction

endpackage

// File: rtl/xir_bank.sv
module xir_bank
    import xir_pkg::*;
#(
    parameter int NUM_WORDS = DEF_WORDS,
    parameter int LANES     = 4,
    parameter int WIDX_W    = 3,
    parameter int WIN_BYTES = NUM_WORDS * LANES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [WIDX_W-1:0]             wr_idx,
    input  logic [LANES*BYTE_W-1:0]       wr_data,
    output logic [WIN_BYTES*BYTE_W-1:0]   win_flat
);

    logic [LANES*BYTE_W-1:0] regs [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_WORDS; n++) regs[n] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // window byte 4n+k sits in the k-th most significant lane of word n
    for (genvar n = 0; n < NUM_WORDS; n++) begin : g_word
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign win_flat[(n*LANES + k)*BYTE_W +: BYTE_W] =
                regs[n][(LANES-1-k)*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/xir_index_ctl.sv
module xir_index_ctl
    import xir_pkg::*;
#(
    parameter int PTR_W     = 5,
    parameter int LANES     = 4,
    parameter int IDX_LAT   = DEF_LAT,
    parameter int WIN_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr_en,
    input  logic [CTRL_W-1:0] idx_wr_addr,
    input  logic              rd_en,
    input  logic              rd_inc,
    output logic [PTR_W-1:0]  ptr,
    output logic              land,
    output logic [PTR_W-1:0]  land_addr
);

    localparam logic [CTRL_W-1:0] WIN_MOD = CTRL_W'(WIN_BYTES);
    localparam logic [PTR_W-1:0]  STEP    = PTR_W'(LANES);

    idx_load_t landing;

    if (IDX_LAT <= 1) begin : g_direct
        assign landing.vld  = idx_wr_en;
        assign landing.addr = idx_wr_addr;
    end else begin : g_pipe
        localparam int DEPTH = IDX_LAT - 1;
        idx_load_t pipe [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
            end else begin
                pipe[0] <= '{vld: idx_wr_en, addr: idx_wr_addr};
                for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            end
        end

        assign landing = pipe[DEPTH-1];
    end

    assign land      = landing.vld;
    assign land_addr = PTR_W'(landing.addr % WIN_MOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (land) begin
            ptr <= land_addr;
        end else if (rd_en && rd_inc) begin
            ptr <= ptr + STEP;
        end
    end

endmodule

// File: rtl/xir_align.sv
module xir_align
    import xir_pkg::*;
#(
    parameter int PTR_W     = 5,
    parameter int LANES     = 4,
    parameter int WIN_BYTES = 32
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] win_flat,
    input  logic [PTR_W-1:0]            ptr,
    output logic [LANES*BYTE_W-1:0]     word
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [PTR_W-1:0] pos;
        assign pos = ptr + PTR_W'(j);
        assign word[(LANES-1-j)*BYTE_W +: BYTE_W] = win_flat[pos*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/xir_index_reader.sv
module xir_index_reader
    import xir_pkg::*;
#(
    parameter int NUM_WORDS = DEF_WORDS,
    parameter int WORD_W    = DEF_WORD_W,
    parameter int IDX_LAT   = DEF_LAT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0]  wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          idx_wr_en,
    input  logic [CTRL_W-1:0]             idx_wr_addr,
    input  logic                          rd_en,
    input  logic                          rd_inc,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          rd_valid
);

    localparam int LANES     = lanes_of(WORD_W);
    localparam int WIN_BYTES = NUM_WORDS * LANES;
    localparam int PTR_W     = $clog2(WIN_BYTES);
    localparam int WIDX_W    = $clog2(NUM_WORDS);

    logic [WIN_BYTES*BYTE_W-1:0] win_flat;
    logic [PTR_W-1:0]            ptr;
    logic                        idx_land;
    logic [PTR_W-1:0]            idx_land_addr;
    logic [WORD_W-1:0]           aligned;

    xir_bank #(
        .NUM_WORDS (NUM_WORDS),
        .LANES     (LANES),
        .WIDX_W    (WIDX_W),
        .WIN_BYTES (WIN_BYTES)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .win_flat (win_flat)
    );

    xir_index_ctl #(
        .PTR_W     (PTR_W),
        .LANES     (LANES),
        .IDX_LAT   (IDX_LAT),
        .WIN_BYTES (WIN_BYTES)
    ) u_idx (
        .clk         (clk),
        .rst         (rst),
        .idx_wr_en   (idx_wr_en),
        .idx_wr_addr (idx_wr_addr),
        .rd_en       (rd_en),
        .rd_inc      (rd_inc),
        .ptr         (ptr),
        .land        (idx_land),
        .land_addr   (idx_land_addr)
    );

    xir_align #(
        .PTR_W     (PTR_W),
        .LANES     (LANES),
        .WIN_BYTES (WIN_BYTES)
    ) u_align (
        .win_flat (win_flat),
        .ptr      (ptr),
        .word     (aligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= aligned;
        end
    end

endmodule

// File: rtl/xir_checker.sv
module xir_checker #(
    parameter int PTR_W = 5,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             rd_inc,
    input logic             rd_valid,
    input logic [PTR_W-1:0] ptr,
    input logic             land,
    input logic [PTR_W-1:0] land_addr
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> !rd_valid);

    assert_valid_follows_read_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_no_valid_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    assert_inc_wraps_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_inc && !land) |=> ptr == PTR_W'($past(ptr) + PTR_W'(LANES)));

    assert_hold_without_read_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !land) |=> $stable(ptr));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        land |=> ptr == $past(land_addr));

endmodule

bind xir_index_reader xir_checker #(
    .PTR_W (PTR_W),
    .LANES (LANES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_inc    (rd_inc),
    .rd_valid  (rd_valid),
    .ptr       (ptr),
    .land      (idx_land),
    .land_addr (idx_land_addr)
);

// File: tb/tb_xir_index_reader.sv
`timescale 1ns/1ps
module tb_xir_index_reader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        idx_wr_en = 1'b0;
    logic [7:0]  idx_wr_addr = '0;
    logic        rd_en = 1'b0;
    logic        rd_inc = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] mb [32];

    always #2 clk = ~clk;

    xir_index_reader dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .idx_wr_en(idx_wr_en), .idx_wr_addr(idx_wr_addr), .rd_en(rd_en),
        .rd_inc(rd_inc), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int p);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[31-8*j -: 8] = mb[(p + j) % 32];
        return w;
    endfunction

    task automatic wr_word(input int n, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = 3'(n); wr_data = d;
        cyc();
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) mb[4*n + k] = d[31-8*k -: 8];
    endtask

    task automatic set_idx(input logic [7:0] a);
        idx_wr_en = 1'b1; idx_wr_addr = a;
        cyc();
        idx_wr_en = 1'b0;
        cyc();
        cyc();
    endtask

    task automatic rd(input bit inc, input string req, input logic [31:0] exp);
        rd_en = 1'b1; rd_inc = inc;
        cyc();
        rd_en = 1'b0; rd_inc = 1'b0;
        chk(rd_valid === 1'b1, {req, " valid"}, {31'd0, rd_valid}, 32'd1);
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        for (int b = 0; b < 32; b++) mb[b] = 8'h00;
        @(negedge clk);
        cyc(); cyc();
        // R1: outputs cleared in reset
        chk(rd_valid === 1'b0, "R1 valid in reset", {31'd0, rd_valid}, 32'd0);
        chk(rd_data === 32'd0, "R1 data in reset", rd_data, 32'd0);
        rst = 1'b0;
        chk(rd_valid === 1'b0, "R1 valid after reset", {31'd0, rd_valid}, 32'd0);
        rd(1'b0, "R1 bank cleared", 32'd0);

        // R2: fill the bank with a pattern computed per byte
        for (int n = 0; n < 8; n++) begin
            logic [31:0] d;
            for (int k = 0; k < 4; k++) d[31-8*k -: 8] = 8'((4*n + k) * 7 + 8'h31);
            wr_word(n, d);
        end
        set_idx(8'h00);
        rd(1'b0, "R2 word0 layout", exp_word(0));

        // R3 R4 R5 R7: sweep every start byte, then a post-incremented follow-up
        for (int p = 0; p < 32; p++) begin
            logic [7:0] a;
            a = (p % 2 == 1) ? (8'(p) | 8'hE0) : 8'(p);
            set_idx(a);
            rd(1'b1, (p > 28) ? "R4 wrap read" : ((p % 2 == 1) ? "R5 upper bits ignored" : "R3 aligned read"),
               exp_word(p));
            rd(1'b1, "R7 post-increment", exp_word((p + 4) % 32));
        end

        // R6: reads one and two cycles after a pointer write use the old pointer
        set_idx(8'h04);
        idx_wr_en = 1'b1; idx_wr_addr = 8'h09;
        cyc();
        idx_wr_en = 1'b0;
        rd(1'b0, "R6 t+1 old pointer", exp_word(4));
        rd(1'b0, "R6 t+2 old pointer", exp_word(4));
        rd(1'b0, "R6 t+3 new pointer", exp_word(9));

        // R9: landing pointer write beats a simultaneous increment
        set_idx(8'h00);
        idx_wr_en = 1'b1; idx_wr_addr = 8'h14;
        cyc();
        idx_wr_en = 1'b0;
        rd(1'b1, "R9 inc before landing", exp_word(0));
        rd(1'b1, "R9 inc at landing", exp_word(4));
        rd(1'b0, "R9 written address wins", exp_word(20));

        // R8: increment without read is ignored
        set_idx(8'h08);
        rd_inc = 1'b1;
        cyc();
        rd_inc = 1'b0;
        chk(rd_valid === 1'b0, "R8 no valid without read", {31'd0, rd_valid}, 32'd0);
        rd(1'b0, "R8 pointer unchanged", exp_word(8));

        // R10: read during write of the same register returns old contents
        begin
            logic [31:0] old_w;
            old_w = exp_word(8);
            wr_en = 1'b1; wr_idx = 3'd2; wr_data = 32'hDEADBEEF;
            rd_en = 1'b1;
            cyc();
            wr_en = 1'b0; rd_en = 1'b0;
            chk(rd_data === old_w, "R10 read during write", rd_data, old_w);
            for (int k = 0; k < 4; k++) mb[8 + k] = wr_data[31-8*k -: 8];
            rd(1'b0, "R10 new contents after write", exp_word(8));
        end

        finish_run();
    end

endmodule